// File: doc/BRIEF.md
# Handshaked Shift-Register Byte Transfer Engine

This block moves packet bytes in both directions between a host processor and a local peripheral controller through a single 8-bit shift register. Three active-low handshake lines on an 8-bit port pace the transfer. The host drives the in-progress and acknowledge lines by writing the port. The engine answers on the request line. A direction input selects one of two modes. In host-to-device mode, each step copies the shift register into a 16-entry outbound buffer. In device-to-host mode, each step fills the shift register from a 128-entry inbound buffer that a local packet source loads.

Every port write is compared with the in-progress/acknowledge pair stored from the previous port write, never with the live pins. Steps advance on any change of that pair. When the in-progress line goes idle, the packet ends. While the line stays idle, the request line follows acknowledge toggles as a synchronisation handshake. For each event that would set the shift-register interrupt flag, the engine emits a one-cycle strobe. When a host packet ends, it issues a one-cycle packet-received strobe with the byte count, and a downstream decoder can read the outbound bytes by index.

Top module: `hsk_xfer_engine`

## Requirements
- R1: After reset, `treq_n` is 1, `sr_q` is 0, and `sr_flag_set` and `pkt_rx` are 0. The stored previous pair is idle: in-progress (port bit 5) = 1 and acknowledge (port bit 4) = 1.
- R2: In host-to-device mode (`h2d_mode`=1), a port write with bit 5 = 0 whose bit5/bit4 pair differs from the stored pair stores `sr_q` at the next free outbound index. It also pulses `sr_flag_set` in the following cycle.
- R3: A port write with bit 5 = 0 whose pair equals the stored pair takes no step: no flag, no store, `sr_q` unchanged.
- R4: With 16 bytes already held, further host-to-device steps are ignored: no flag and no store.
- R5: In device-to-host mode (`h2d_mode`=0), a step while unsent inbound bytes remain loads the next inbound byte into `sr_q` and pulses the flag. On the step that loads the last byte, `treq_n` goes to 1. A step with nothing left does nothing.
- R6: A port write with bit 5 = 1, where the stored bit 5 is also 1 and bit 4 differs from the stored bit 4, sets `treq_n` to the new bit 4 and pulses the flag.
- R7: A port write with bit 5 = 1 while the stored bit 5 is 0 always pulses the flag. If the outbound buffer holds N>0 bytes, `pkt_rx` pulses for one cycle with `pkt_rx_len`=N, and the outbound count returns to 0.
- R8: On any port write with bit 5 = 1 that is not the R6 case, `treq_n` goes to 0 if unsent inbound bytes remain.
- R9: `src_commit` sets the inbound length to `src_len`, resets the read index to 0 and pulses the flag. If the stored bit 5 is 1 and `src_len`>0, it also drives `treq_n` to 0. A port write in the same cycle is dropped.
- R10: `ob_rd_byte` returns the byte stored at outbound index `ob_rd_idx` in the same cycle.
- R11: `sr_wr` loads `sr_wdata` into `sr_q` unless a device-to-host step loads it in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h2d_mode | input | 1 | 1: host shifts out to device; 0: device sends to host |
| pb_wr | input | 1 | Host write strobe for the handshake port |
| pb_wdata | input | 8 | Port value written; bit 5 in-progress, bit 4 acknowledge (active low) |
| sr_wr | input | 1 | Host write strobe for the shift register |
| sr_wdata | input | 8 | Shift register write value |
| src_wr | input | 1 | Packet source writes one inbound byte |
| src_widx | input | 7 | Inbound byte index |
| src_wbyte | input | 8 | Inbound byte value |
| src_commit | input | 1 | Packet source commits a new inbound packet |
| src_len | input | 8 | Inbound packet length, 0..128 |
| treq_n | output | 1 | Active-low transfer request (port bit 3) |
| sr_q | output | 8 | Shift register contents |
| sr_flag_set | output | 1 | One-cycle strobe that sets the shift-register interrupt flag |
| pkt_rx | output | 1 | One-cycle packet-received strobe |
| pkt_rx_len | output | 5 | Byte count, valid with `pkt_rx` |
| ob_rd_idx | input | 4 | Outbound buffer read index |
| ob_rd_byte | output | 8 | Outbound byte at `ob_rd_idx` |

## Verification
Most internal errors show up on the ports within one cycle of the port write that exposes them. A wrong stored pair turns a step into a no-op, or a sync toggle into an end of packet, and so changes `sr_flag_set` on the very next clock. A drifting outbound count shows up as a wrong `pkt_rx_len`, or as a missing or extra store. Those stay hidden until the packet ends and the buffer is read back. A wrong inbound index shows as a wrong `sr_q` byte, or as `treq_n` releasing one step early or late. A reference model updated every clock is compared with every output after each edge.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
  // Handshake port bit positions (active low); the host software decodes these.
  localparam int REQ_BIT = 3;
  localparam int ACK_BIT = 4;
  localparam int PRG_BIT = 5;

  // Classification of one handshake-port write
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,  // no write, or in-progress with unchanged pair
    ACT_STEP = 2'd1,  // in-progress, pair changed: move one byte
    ACT_SYNC = 2'd2,  // idle, was idle, acknowledge toggled
    ACT_IDLE = 2'd3   // idle otherwise (includes end of packet)
  } hsk_act_e;
endpackage

// File: rtl/hsk_phase_decode.sv
module hsk_phase_decode
  import hsk_pkg::*;
(
  input  logic     wr,
  input  logic     prg_n,
  input  logic     ack_n,
  input  logic     prev_prg_n,
  input  logic     prev_ack_n,
  output hsk_act_e act
);
  always_comb begin
    act = ACT_NONE;
    if (wr) begin
      if (!prg_n) begin
        if ((prg_n != prev_prg_n) || (ack_n != prev_ack_n)) act = ACT_STEP;
      end else if (prev_prg_n && (ack_n != prev_ack_n)) begin
        act = ACT_SYNC;
      end else begin
        act = ACT_IDLE;
      end
    end
  end
endmodule

// File: rtl/hsk_outbuf.sv
module hsk_outbuf #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] ent_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_en && (wr_idx == IW'(i))) ent_q[i] <= wr_data;
      end
    end
  end

  assign rd_data = ent_q[rd_idx];
endmodule

// File: rtl/hsk_inbuf.sv
module hsk_inbuf #(
  parameter int W     = 8,
  parameter int DEPTH = 128,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);
  // Plain storage array: no reset, contents defined by the packet source.
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/hsk_ctrl.sv
module hsk_ctrl
  import hsk_pkg::*;
#(
  parameter int W        = 8,
  parameter int OB_DEPTH = 16,
  parameter int IB_DEPTH = 128,
  localparam int OCW     = $clog2(OB_DEPTH + 1),
  localparam int OIW     = $clog2(OB_DEPTH),
  localparam int ICW     = $clog2(IB_DEPTH + 1),
  localparam int IIW     = $clog2(IB_DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           h2d_mode,
  input  logic           pb_wr,
  input  logic           prg_n,
  input  logic           ack_n,
  input  logic           sr_wr,
  input  logic [W-1:0]   sr_wdata,
  input  logic           src_commit,
  input  logic [ICW-1:0] src_len,
  input  logic [W-1:0]   in_byte,
  output logic [IIW-1:0] in_rd_idx,
  output logic           ob_wr_en,
  output logic [OIW-1:0] ob_wr_idx,
  output logic [W-1:0]   ob_wr_data,
  output logic           treq_n,
  output logic [W-1:0]   sr_q,
  output logic           flag_set,
  output logic           pkt_rx,
  output logic [OCW-1:0] pkt_len
);
  // State registers
  logic           prev_prg_q, prev_ack_q;
  logic           treq_q;
  logic [W-1:0]   sr_r;
  logic [OCW-1:0] ob_cnt_q;
  logic [ICW-1:0] rd_idx_q, in_size_q;
  logic           flag_q, pkt_q;
  logic [OCW-1:0] len_q;

  // Next-state values
  logic           prev_prg_d, prev_ack_d;
  logic           treq_d;
  logic [W-1:0]   sr_d;
  logic [OCW-1:0] ob_cnt_d;
  logic [ICW-1:0] rd_idx_d, in_size_d;
  logic           flag_d, pkt_d;
  logic [OCW-1:0] len_d;

  hsk_act_e       act;
  logic           pb_take;
  logic           ob_room, in_left;
  logic [ICW-1:0] rd_inc;

  // A commit in the same cycle drops the port write entirely.
  assign pb_take = pb_wr && !src_commit;

  hsk_phase_decode u_dec (
    .wr         (pb_take),
    .prg_n      (prg_n),
    .ack_n      (ack_n),
    .prev_prg_n (prev_prg_q),
    .prev_ack_n (prev_ack_q),
    .act        (act)
  );

  assign ob_room = (ob_cnt_q < OCW'(OB_DEPTH));
  assign in_left = (rd_idx_q < in_size_q);
  assign rd_inc  = rd_idx_q + ICW'(1);

  always_comb begin
    prev_prg_d = prev_prg_q;
    prev_ack_d = prev_ack_q;
    treq_d     = treq_q;
    sr_d       = sr_r;
    ob_cnt_d   = ob_cnt_q;
    rd_idx_d   = rd_idx_q;
    in_size_d  = in_size_q;
    flag_d     = 1'b0;
    pkt_d      = 1'b0;
    len_d      = '0;
    ob_wr_en   = 1'b0;

    if (sr_wr) sr_d = sr_wdata;

    if (src_commit) begin
      in_size_d = src_len;
      rd_idx_d  = '0;
      flag_d    = 1'b1;
      if (prev_prg_q && (src_len != '0)) treq_d = 1'b0;
    end else begin
      unique case (act)
        ACT_STEP: begin
          if (h2d_mode) begin
            if (ob_room) begin
              ob_wr_en = 1'b1;
              ob_cnt_d = ob_cnt_q + OCW'(1);
              flag_d   = 1'b1;
            end
          end else if (in_left) begin
            sr_d     = in_byte;
            rd_idx_d = rd_inc;
            flag_d   = 1'b1;
            if (rd_inc >= in_size_q) treq_d = 1'b1;
          end
        end
        ACT_SYNC: begin
          treq_d = ack_n;
          flag_d = 1'b1;
        end
        ACT_IDLE: begin
          if (!prev_prg_q) begin
            flag_d = 1'b1;
            if (ob_cnt_q != '0) begin
              pkt_d    = 1'b1;
              len_d    = ob_cnt_q;
              ob_cnt_d = '0;
            end
          end
          if (in_left) treq_d = 1'b0;
        end
        default: ;
      endcase
      if (pb_take) begin
        prev_prg_d = prg_n;
        prev_ack_d = ack_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_prg_q <= 1'b1;
      prev_ack_q <= 1'b1;
      treq_q     <= 1'b1;
      sr_r       <= '0;
      ob_cnt_q   <= '0;
      rd_idx_q   <= '0;
      in_size_q  <= '0;
      flag_q     <= 1'b0;
      pkt_q      <= 1'b0;
      len_q      <= '0;
    end else begin
      prev_prg_q <= prev_prg_d;
      prev_ack_q <= prev_ack_d;
      treq_q     <= treq_d;
      sr_r       <= sr_d;
      ob_cnt_q   <= ob_cnt_d;
      rd_idx_q   <= rd_idx_d;
      in_size_q  <= in_size_d;
      flag_q     <= flag_d;
      pkt_q      <= pkt_d;
      len_q      <= len_d;
    end
  end

  assign in_rd_idx  = rd_idx_q[IIW-1:0];
  assign ob_wr_idx  = ob_cnt_q[OIW-1:0];
  assign ob_wr_data = sr_r;
  assign treq_n     = treq_q;
  assign sr_q       = sr_r;
  assign flag_set   = flag_q;
  assign pkt_rx     = pkt_q;
  assign pkt_len    = len_q;

  // R4
  ob_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ob_cnt_q <= OCW'(OB_DEPTH));

  // R2
  ob_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ob_cnt_q != $past(ob_cnt_q)) |-> ((ob_cnt_q == $past(ob_cnt_q) + OCW'(1)) || (ob_cnt_q == '0)));

  // R5
  rd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx_q <= in_size_q);

  // R7
  pkt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_q |=> !pkt_q);

  // R7
  pkt_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_q |-> ((len_q != '0) && flag_q && (ob_cnt_q == '0)));

  // R5
  treq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ob_wr_en == 1'b0 && act == ACT_STEP && !h2d_mode && in_left && (rd_inc >= in_size_q) && !src_commit) |=> treq_q);
endmodule

// File: rtl/hsk_xfer_engine.sv
module hsk_xfer_engine
  import hsk_pkg::*;
#(
  parameter int W        = 8,
  parameter int OB_DEPTH = 16,
  parameter int IB_DEPTH = 128
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          h2d_mode,
  input  logic                          pb_wr,
  input  logic [7:0]                    pb_wdata,
  input  logic                          sr_wr,
  input  logic [W-1:0]                  sr_wdata,
  input  logic                          src_wr,
  input  logic [$clog2(IB_DEPTH)-1:0]   src_widx,
  input  logic [W-1:0]                  src_wbyte,
  input  logic                          src_commit,
  input  logic [$clog2(IB_DEPTH+1)-1:0] src_len,
  output logic                          treq_n,
  output logic [W-1:0]                  sr_q,
  output logic                          sr_flag_set,
  output logic                          pkt_rx,
  output logic [$clog2(OB_DEPTH+1)-1:0] pkt_rx_len,
  input  logic [$clog2(OB_DEPTH)-1:0]   ob_rd_idx,
  output logic [W-1:0]                  ob_rd_byte
);
  localparam int OIW = $clog2(OB_DEPTH);
  localparam int IIW = $clog2(IB_DEPTH);

  logic           ob_wr_en;
  logic [OIW-1:0] ob_wr_idx;
  logic [W-1:0]   ob_wr_data;
  logic [IIW-1:0] in_rd_idx;
  logic [W-1:0]   in_byte;
  logic           pb_unused;

  // Only the in-progress and acknowledge bits take part in the handshake.
  assign pb_unused = ^{pb_wdata[7:6], pb_wdata[REQ_BIT], pb_wdata[2:0]};

  hsk_ctrl #(.W(W), .OB_DEPTH(OB_DEPTH), .IB_DEPTH(IB_DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .h2d_mode   (h2d_mode),
    .pb_wr      (pb_wr),
    .prg_n      (pb_wdata[PRG_BIT]),
    .ack_n      (pb_wdata[ACK_BIT]),
    .sr_wr      (sr_wr),
    .sr_wdata   (sr_wdata),
    .src_commit (src_commit),
    .src_len    (src_len),
    .in_byte    (in_byte),
    .in_rd_idx  (in_rd_idx),
    .ob_wr_en   (ob_wr_en),
    .ob_wr_idx  (ob_wr_idx),
    .ob_wr_data (ob_wr_data),
    .treq_n     (treq_n),
    .sr_q       (sr_q),
    .flag_set   (sr_flag_set),
    .pkt_rx     (pkt_rx),
    .pkt_len    (pkt_rx_len)
  );

  hsk_outbuf #(.W(W), .DEPTH(OB_DEPTH)) u_ob (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ob_wr_en),
    .wr_idx  (ob_wr_idx),
    .wr_data (ob_wr_data),
    .rd_idx  (ob_rd_idx),
    .rd_data (ob_rd_byte)
  );

  hsk_inbuf #(.W(W), .DEPTH(IB_DEPTH)) u_ib (
    .clk     (clk),
    .wr_en   (src_wr),
    .wr_idx  (src_widx),
    .wr_data (src_wbyte),
    .rd_idx  (in_rd_idx),
    .rd_data (in_byte)
  );
endmodule

// File: tb/hsk_xfer_engine_tb_top.sv
module hsk_xfer_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       h2d_mode = 1'b1;
  logic       pb_wr = 1'b0;
  logic [7:0] pb_wdata = 8'hFF;
  logic       sr_wr = 1'b0;
  logic [7:0] sr_wdata = 8'h00;
  logic       src_wr = 1'b0;
  logic [6:0] src_widx = '0;
  logic [7:0] src_wbyte = '0;
  logic       src_commit = 1'b0;
  logic [7:0] src_len = '0;
  logic [3:0] ob_rd_idx = '0;
  logic       treq_n, sr_flag_set, pkt_rx;
  logic [7:0] sr_q, ob_rd_byte;
  logic [4:0] pkt_rx_len;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsk_xfer_engine dut_i (
    .clk(clk), .rst_n(rst_n), .h2d_mode(h2d_mode), .pb_wr(pb_wr), .pb_wdata(pb_wdata),
    .sr_wr(sr_wr), .sr_wdata(sr_wdata), .src_wr(src_wr), .src_widx(src_widx),
    .src_wbyte(src_wbyte), .src_commit(src_commit), .src_len(src_len),
    .treq_n(treq_n), .sr_q(sr_q), .sr_flag_set(sr_flag_set), .pkt_rx(pkt_rx),
    .pkt_rx_len(pkt_rx_len), .ob_rd_idx(ob_rd_idx), .ob_rd_byte(ob_rd_byte)
  );

  // ---------------- behavioural reference model ----------------
  bit       m_prev_prg, m_prev_ack, m_treq;
  byte      m_sr;
  byte      ob_q[$];
  byte      ob_mem[16];
  byte      ib_mem[128];
  int       m_size, m_idx;
  bit       e_flag, e_pkt;
  int       e_len;
  byte      sr_before;
  bit       w_prg, w_ack;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev_prg = 1; m_prev_ack = 1; m_treq = 1; m_sr = 0;
      ob_q.delete(); m_size = 0; m_idx = 0;
      e_flag = 0; e_pkt = 0; e_len = 0;
      for (int i = 0; i < 16; i++) ob_mem[i] = 0;
    end else begin
      e_flag = 0; e_pkt = 0; e_len = 0;
      if (src_wr) ib_mem[src_widx] = src_wbyte;
      if (src_commit) begin
        m_size = int'(src_len); m_idx = 0; e_flag = 1;
        if (m_prev_prg && src_len != 0) m_treq = 0;
      end else begin
        sr_before = m_sr;
        if (sr_wr) m_sr = sr_wdata;
        if (pb_wr) begin
          w_prg = pb_wdata[5]; w_ack = pb_wdata[4];
          if (!w_prg) begin
            if (w_prg != m_prev_prg || w_ack != m_prev_ack) begin
              if (h2d_mode) begin
                if (ob_q.size() < 16) begin
                  ob_mem[ob_q.size()] = sr_before;
                  ob_q.push_back(sr_before);
                  e_flag = 1;
                end
              end else if (m_idx < m_size) begin
                m_sr = ib_mem[m_idx];
                m_idx++;
                if (m_idx >= m_size) m_treq = 1;
                e_flag = 1;
              end
            end
          end else if (m_prev_prg && w_ack != m_prev_ack) begin
            m_treq = w_ack; e_flag = 1;
          end else begin
            if (!m_prev_prg) begin
              e_flag = 1;
              if (ob_q.size() > 0) begin
                e_pkt = 1; e_len = ob_q.size(); ob_q.delete();
              end
            end
            if (m_idx < m_size) m_treq = 0;
          end
          m_prev_prg = w_prg; m_prev_ack = w_ack;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(treq_n == m_treq, "R5/R6/R8/R9 treq_n", treq_n, m_treq);
      check(sr_q == 8'(m_sr), "R2/R5/R11 sr_q", sr_q, 8'(m_sr));
      check(sr_flag_set == e_flag, "R2/R3/R4/R7 sr_flag_set", sr_flag_set, e_flag);
      check(pkt_rx == e_pkt, "R7 pkt_rx", pkt_rx, e_pkt);
      if (e_pkt) check(pkt_rx_len == 5'(e_len), "R7 pkt_rx_len", pkt_rx_len, e_len);
    end
  end

  // ---------------- stimulus ----------------
  task automatic pb_put(input bit prg, input bit ack);
    pb_wr = 1; pb_wdata = {2'b11, prg, ack, 4'hF};
    @(negedge clk); pb_wr = 0;
  endtask

  task automatic sr_put(input byte v);
    sr_wr = 1; sr_wdata = v;
    @(negedge clk); sr_wr = 0;
  endtask

  task automatic load_pkt(input int len, input byte base);
    for (int i = 0; i < len; i++) begin
      src_wr = 1; src_widx = 7'(i); src_wbyte = 8'(base + i);
      @(negedge clk);
    end
    src_wr = 0; src_commit = 1; src_len = 8'(len);
    @(negedge clk); src_commit = 0;
  endtask

  task automatic readback(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      ob_rd_idx = 4'(k); #1;
      check(ob_rd_byte == 8'(ob_mem[k]), req, ob_rd_byte, 8'(ob_mem[k]));
    end
    ob_rd_idx = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values visible before release
    check(treq_n == 1'b1 && sr_q == 8'h00 && !sr_flag_set && !pkt_rx, "R1 reset", {treq_n, sr_q}, 9'h100);
    rst_n = 1;
    @(negedge clk);

    // R2, R3, R11: host-to-device packet of three bytes
    h2d_mode = 1;
    sr_put(8'hA1);                   // R11
    pb_put(0, 1);                    // R2 step
    sr_put(8'hB2);
    pb_put(0, 0);                    // step
    pb_put(0, 0);                    // R3 unchanged pair: no step
    sr_put(8'hC3);
    pb_put(0, 1);
    pb_put(1, 1);                    // R7 end: len 3
    @(negedge clk);
    readback(3, "R10 outbound readback");

    // R4: overfill with 18 steps, then end
    for (int i = 0; i < 18; i++) begin
      sr_put(byte'(8'h40 + i));
      pb_put(0, i[0]);
    end
    pb_put(1, 1);
    @(negedge clk);
    readback(16, "R4/R10 full buffer readback");

    // R6: sync toggles while idle
    pb_put(1, 0);
    pb_put(1, 1);
    pb_put(1, 0);
    pb_put(1, 1);

    // R9, R5, R8: device-to-host packet of three bytes
    h2d_mode = 0;
    load_pkt(3, 8'h70);
    pb_put(0, 1);
    pb_put(0, 0);
    pb_put(0, 1);                    // last byte: treq released
    pb_put(0, 0);                    // nothing left
    pb_put(1, 1);                    // end, empty outbound: no pkt_rx

    // R9 while in progress, R8 on end with bytes remaining
    pb_put(0, 1);
    load_pkt(4, 8'h20);
    pb_put(0, 0);
    pb_put(0, 1);
    pb_put(1, 1);                    // idle with 2 left: treq low
    pb_put(1, 0);                    // sync
    pb_put(0, 0);
    pb_put(0, 1);
    pb_put(1, 1);
    load_pkt(0, 8'h00);              // zero length: no request
    repeat (3) @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule